// File: doc/BRIEF.md
# One-Time-Programmable ROM Bus Model

This block is a clock-driven, synthesizable stand-in for a byte-wide one-time-programmable ROM. Device programmers and bus controllers can be tested against it. On each clock edge it samples an address, an active-low chip select, an active-low output enable, a flag that says the programming supply is present, a flag that says the high identification voltage sits on address line 9, and a write byte. From these it decides the bus mode and drives a read byte together with a drive-enable. Access and float times are given in nanoseconds and turned into whole clock cycles.

Three event timers run separately: one for a change of address (or of the identification flag), one for a fall of chip select, and one for a fall of output enable. Read data appears only once all three timers have expired. Until then the bus is driven with a fixed "not yet valid" marker byte. Programming can only clear bits: a pulse stores the AND of the old byte and the write byte.

The mode machine has eight states:
- STANDBY: chip select is high.
- OUTOFF: chip select is low and output enable is high.
- ACCESS: a timer is still running.
- READ: data is valid.
- IDENT: a signature byte is valid.
- FLOAT: the output is still driven after a deselect.
- PROG: a programming pulse is active.
- INHIBIT: the programming supply is present and chip select is high.

Transitions:
- Programming supply present: every state goes to PROG when chip select is low, or to INHIBIT when it is high.
- Read enabled: every state goes to ACCESS while a timer is running or an event is seen, and then to READ or IDENT.
- Disabled: ACCESS, READ and IDENT go to FLOAT. FLOAT stays for the float window and then goes to STANDBY or OUTOFF. All other states go straight to STANDBY or OUTOFF.

Top module: `otp_rom_model`

## Requirements
- R1: Storage holds 2**ARR_AW bytes (default 1024; 16 gives the full 64K), indexed by the low ARR_AW address bits, so the upper bits alias. After reset every byte reads 0xFF.
- R2: With chip_sel_n=0, out_en_n=0, prog_volt=0 and id_volt=0, rd_drive is 1 from the edge after the first such sample on. Once valid, rd_data is the stored byte.
- R3: With prog_volt=0 and either chip_sel_n=1 (standby) or chip_sel_n=0 with out_en_n=1 (output off), rd_drive=0 and rd_data=0x00 once any float window has ended.
- R4: With id_volt=1 in an otherwise enabled read, the valid byte is 0x1E when addr[0]=0 and 0x0D when addr[0]=1. All other address bits are ignored.
- R5: The first sample of chip_sel_n=0 under prog_volt=1 replaces the addressed byte with (old AND wr_data). While prog_volt=1, rd_drive is 0.
- R6: With prog_volt=1 and chip_sel_n=1, no byte changes, whatever wr_data is.
- R7: Let E0 be the edge that first samples an address or id_volt change during a read. The marker 0xA5 is driven through edge E0+4, and the data is valid after edge E0+5 (45 ns at a 10 ns clock).
- R8: The same rule holds after a chip-select fall (5 cycles) and after an output-enable fall (2 cycles). Data waits for the latest timer. An output-enable fall sampled up to 3 edges after the chip-select fall does not delay data; one sampled 4 edges after it does.
- R9: When chip select or output enable rises out of a driven read state at edge E0, the marker stays driven through edge E0+1. The output is released after edge E0+2.
- R10: During and right after reset the block is in STANDBY with rd_drive=0 and rd_data=0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Byte address |
| chip_sel_n | input | 1 | Active-low chip select |
| out_en_n | input | 1 | Active-low output enable |
| prog_volt | input | 1 | Programming supply present on the output-enable pin |
| id_volt | input | 1 | High identification voltage present on address line 9 |
| wr_data | input | 8 | Byte to program |
| rd_data | output | 8 | Read byte, marker, signature, or 0x00 when released |
| rd_drive | output | 1 | Bus drive-enable |

## Verification
Two things can land on the same clock edge: the last running timer expiring, and a fresh event that restarts one. When they coincide, the block must show the marker again rather than stale data. The bench provokes this by changing the address, then the identification flag, during a read that has already settled. It checks that the marker appears from the very next edge and that new data comes exactly five edges after the change. The output-enable timer and the chip-select timer are also made to overlap: output enable falls three and then four edges after chip select. Valid data must come at the same edge in the first case and one edge later in the second.

// File: rtl/otp_pkg.sv
package otp_pkg;

    typedef enum logic [2:0] {
        ST_STANDBY,
        ST_OUTOFF,
        ST_ACCESS,
        ST_READ,
        ST_IDENT,
        ST_FLOAT,
        ST_PROG,
        ST_INHIBIT
    } bus_mode_e;

    function automatic int ns_to_cycles(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max_of3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/otp_event_timer.sv
module otp_event_timer #(
    parameter int LIMIT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= CW'(LIMIT - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/otp_delay_track.sv
module otp_delay_track #(
    parameter int ADDR_W = 16,
    parameter int ACC_CYC = 5,
    parameter int CE_CYC  = 5,
    parameter int OE_CYC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              id_volt,
    input  logic              chip_sel_n,
    input  logic              out_en_n,
    output logic              ready,
    output logic              sel0_q
);
    localparam int N_TMR = 3;

    logic [ADDR_W:0] key_q;
    logic            cs_q;
    logic            oe_q;
    logic [N_TMR-1:0] evt;
    logic [N_TMR-1:0] done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q <= '0;
            cs_q  <= 1'b1;
            oe_q  <= 1'b1;
        end else begin
            key_q <= {id_volt, addr};
            cs_q  <= chip_sel_n;
            oe_q  <= out_en_n;
        end
    end

    assign evt[0] = ({id_volt, addr} != key_q);
    assign evt[1] = !chip_sel_n && cs_q;
    assign evt[2] = !out_en_n && oe_q;

    generate
        for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
            localparam int LIM = (g == 0) ? ACC_CYC : ((g == 1) ? CE_CYC : OE_CYC);
            otp_event_timer #(.LIMIT(LIM)) u_tmr (
                .clk     (clk),
                .rst_n   (rst_n),
                .restart (evt[g]),
                .done    (done[g])
            );
        end
    endgenerate

    assign ready  = (&done) && !(|evt);
    assign sel0_q = key_q[0];
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '1;
            end
            rdata <= '1;
        end else begin
            if (we) begin
                cells[idx] <= cells[idx] & wdata;
            end
            rdata <= cells[idx];
        end
    end
endmodule

// File: rtl/otp_rom_model.sv
module otp_rom_model
    import otp_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter int              DATA_W   = 8,
    parameter int              ARR_AW   = 10,
    parameter int              CLK_NS   = 10,
    parameter int              T_ACC_NS = 45,
    parameter int              T_CE_NS  = 45,
    parameter int              T_OE_NS  = 20,
    parameter int              T_DF_NS  = 20,
    parameter logic [DATA_W-1:0] MARK     = 8'hA5,
    parameter logic [DATA_W-1:0] MFG_CODE = 8'h1E,
    parameter logic [DATA_W-1:0] DEV_CODE = 8'h0D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              chip_sel_n,
    input  logic              out_en_n,
    input  logic              prog_volt,
    input  logic              id_volt,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_drive
);
    localparam int ACC_CYC = ns_to_cycles(T_ACC_NS, CLK_NS);
    localparam int CE_CYC  = ns_to_cycles(T_CE_NS, CLK_NS);
    localparam int OE_CYC  = ns_to_cycles(T_OE_NS, CLK_NS);
    localparam int DF_CYC  = ns_to_cycles(T_DF_NS, CLK_NS);
    localparam int DF_W    = $clog2(DF_CYC + 1);

    bus_mode_e         state_q;
    bus_mode_e         state_d;
    logic [DF_W-1:0]   fl_cnt_q;
    logic              ready;
    logic              sel0_q;
    logic              write_en;
    logic [DATA_W-1:0] cell_q;

    otp_delay_track #(
        .ADDR_W  (ADDR_W),
        .ACC_CYC (ACC_CYC),
        .CE_CYC  (CE_CYC),
        .OE_CYC  (OE_CYC)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .id_volt    (id_volt),
        .chip_sel_n (chip_sel_n),
        .out_en_n   (out_en_n),
        .ready      (ready),
        .sel0_q     (sel0_q)
    );

    otp_cell_array #(
        .AW (ARR_AW),
        .DW (DATA_W)
    ) u_cells (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (write_en),
        .idx   (addr[ARR_AW-1:0]),
        .wdata (wr_data),
        .rdata (cell_q)
    );

    // next-state decode
    always_comb begin
        state_d = state_q;
        if (prog_volt) begin
            state_d = chip_sel_n ? ST_INHIBIT : ST_PROG;
        end else if (!chip_sel_n && !out_en_n) begin
            if (!ready) begin
                state_d = ST_ACCESS;
            end else begin
                state_d = id_volt ? ST_IDENT : ST_READ;
            end
        end else begin
            unique case (state_q)
                ST_ACCESS, ST_READ, ST_IDENT: state_d = ST_FLOAT;
                ST_FLOAT: begin
                    if (fl_cnt_q != '0) begin
                        state_d = ST_FLOAT;
                    end else begin
                        state_d = chip_sel_n ? ST_STANDBY : ST_OUTOFF;
                    end
                end
                default: state_d = chip_sel_n ? ST_STANDBY : ST_OUTOFF;
            endcase
        end
    end

    assign write_en = (state_d == ST_PROG) && (state_q != ST_PROG);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_STANDBY;
            fl_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_FLOAT && state_q != ST_FLOAT) begin
                fl_cnt_q <= DF_W'(DF_CYC - 1);
            end else if (fl_cnt_q != '0) begin
                fl_cnt_q <= fl_cnt_q - 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_ACCESS, ST_FLOAT: begin
                rd_drive = 1'b1;
                rd_data  = MARK;
            end
            ST_READ: begin
                rd_drive = 1'b1;
                rd_data  = cell_q;
            end
            ST_IDENT: begin
                rd_drive = 1'b1;
                rd_data  = sel0_q ? DEV_CODE : MFG_CODE;
            end
            default: begin
                rd_drive = 1'b0;
                rd_data  = '0;
            end
        endcase
    end
endmodule

// File: rtl/otp_rom_model_chk.sv
module otp_rom_model_chk #(
    parameter int            AW     = 16,
    parameter int            DW     = 8,
    parameter int            DF_CYC = 2,
    parameter int            LMAX   = 5,
    parameter logic [DW-1:0] MFG    = 8'h1E,
    parameter logic [DW-1:0] DEV    = 8'h0D
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr,
    input logic          chip_sel_n,
    input logic          out_en_n,
    input logic          prog_volt,
    input logic          id_volt,
    input logic [DW-1:0] rd_data,
    input logic          rd_drive
);
    logic [7:0] off_run;
    logic [7:0] rd_run;
    logic [AW:0] key_prev;
    logic        rd_mode;
    logic        off_mode;
    logic [AW:0] key_now;

    assign rd_mode  = !prog_volt && !chip_sel_n && !out_en_n;
    assign off_mode = !prog_volt && (chip_sel_n || out_en_n);
    assign key_now  = {id_volt, addr};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_run  <= '0;
            rd_run   <= '0;
            key_prev <= '0;
        end else begin
            key_prev <= key_now;
            if (!off_mode)            off_run <= '0;
            else if (off_run != 8'hFF) off_run <= off_run + 1'b1;
            if (!rd_mode)                 rd_run <= '0;
            else if (key_now != key_prev) rd_run <= 8'd1;
            else if (rd_run != 8'hFF)     rd_run <= rd_run + 1'b1;
        end
    end

    assert_read_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_mode |=> rd_drive);

    assert_prog_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        prog_volt |=> !rd_drive);

    assert_float_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(off_run) > DF_CYC) |-> !rd_drive);

    assert_ident_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(rd_run) > LMAX) && id_volt && (key_now == key_prev))
        |-> (rd_drive && rd_data == (addr[0] ? DEV : MFG)));
endmodule

bind otp_rom_model otp_rom_model_chk #(
    .AW     (ADDR_W),
    .DW     (DATA_W),
    .DF_CYC (DF_CYC),
    .LMAX   (otp_pkg::max_of3(ACC_CYC, CE_CYC, OE_CYC)),
    .MFG    (MFG_CODE),
    .DEV    (DEV_CODE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .chip_sel_n (chip_sel_n),
    .out_en_n   (out_en_n),
    .prog_volt  (prog_volt),
    .id_volt    (id_volt),
    .rd_data    (rd_data),
    .rd_drive   (rd_drive)
);

// File: tb/otp_rom_model_bench.sv
module otp_rom_model_bench;
    localparam logic [7:0] MARK = 8'hA5;
    localparam int NVEC = 8;
    // {id_volt, addr, expected}
    localparam logic [24:0] VEC [NVEC] = '{
        {1'b0, 16'h0010, 8'h3C},
        {1'b0, 16'h0123, 8'h50},
        {1'b0, 16'h03FF, 8'h81},
        {1'b0, 16'h0200, 8'hFF},
        {1'b1, 16'h0000, 8'h1E},
        {1'b1, 16'h0001, 8'h0D},
        {1'b0, 16'h0410, 8'h3C},
        {1'b1, 16'hFFFE, 8'h1E}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        chip_sel_n = 1'b1;
    logic        out_en_n = 1'b1;
    logic        prog_volt = 1'b0;
    logic        id_volt = 1'b0;
    logic [7:0]  wr_data = 8'hFF;
    logic [7:0]  rd_data;
    logic        rd_drive;
    int          total = 0;
    int          bad = 0;

    always #5 clk = ~clk;

    otp_rom_model u_otp_rom_model (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (addr),
        .chip_sel_n (chip_sel_n),
        .out_en_n   (out_en_n),
        .prog_volt  (prog_volt),
        .id_volt    (id_volt),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .rd_drive   (rd_drive)
    );

    function automatic string vec_tag(input int i);
        case (i)
            0, 2:    return "R2";
            1:       return "R5";
            3, 6:    return "R1";
            default: return "R4";
        endcase
    endfunction

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic en, input logic [7:0] d);
        total++;
        if (rd_drive !== en || rd_data !== d) begin
            bad++;
            $display("FAIL %s: got drive=%0b data=%02h, expected drive=%0b data=%02h",
                     tag, rd_drive, rd_data, en, d);
        end
    endtask

    task automatic burn(input logic [15:0] a, input logic [7:0] d);
        prog_volt = 1'b1; chip_sel_n = 1'b1; addr = a; wr_data = d;
        edges(1);
        chip_sel_n = 1'b0;
        edges(2);
        chk("R5 no drive while programming", 1'b0, 8'h00);
        chip_sel_n = 1'b1;
        edges(1);
        prog_volt = 1'b0;
        edges(1);
    endtask

    task automatic read_cycle(input logic a9, input logic [15:0] a,
                              input logic [7:0] exp_d, input string tag);
        addr = a; id_volt = a9; chip_sel_n = 1'b0; out_en_n = 1'b0;
        edges(5);
        chk({tag, " marker before access delay (R7)"}, 1'b1, MARK);
        edges(1);
        chk(tag, 1'b1, exp_d);
        chip_sel_n = 1'b1; out_en_n = 1'b1;
        edges(2);
        chk("R9 float window driven", 1'b1, MARK);
        edges(1);
        chk("R9 released / R3 standby", 1'b0, 8'h00);
        id_volt = 1'b0;
        edges(1);
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: got no finish, expected finish before timeout");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        edges(2);
        chk("R10 during reset", 1'b0, 8'h00);
        rst_n = 1'b1;
        edges(1);
        chk("R10 after reset", 1'b0, 8'h00);

        burn(16'h0010, 8'h3C);
        burn(16'h0123, 8'hF0);
        burn(16'h0123, 8'h5F);
        burn(16'h03FF, 8'h81);

        for (int i = 0; i < NVEC; i++) begin
            read_cycle(VEC[i][24], VEC[i][23:8], VEC[i][7:0], vec_tag(i));
        end

        // R6: inhibit leaves storage untouched
        prog_volt = 1'b1; chip_sel_n = 1'b1; addr = 16'h0200; wr_data = 8'h00;
        edges(3);
        chk("R5 inhibit no drive", 1'b0, 8'h00);
        prog_volt = 1'b0;
        edges(1);
        read_cycle(1'b0, 16'h0200, 8'hFF, "R6 inhibited byte unchanged");

        // R7: address change during a settled read
        addr = 16'h0010; chip_sel_n = 1'b0; out_en_n = 1'b0;
        edges(6);
        chk("R2 settled read", 1'b1, 8'h3C);
        addr = 16'h03FF;
        edges(1);
        chk("R7 marker right after address change", 1'b1, MARK);
        edges(4);
        chk("R7 marker at last delay edge", 1'b1, MARK);
        edges(1);
        chk("R7 data after address delay", 1'b1, 8'h81);

        // R4/R7: id flag change during read
        addr = 16'h0001; id_volt = 1'b1;
        edges(5);
        chk("R7 marker after id change", 1'b1, MARK);
        edges(1);
        chk("R4 device code", 1'b1, 8'h0D);

        // R9: output enable rise with chip select held
        out_en_n = 1'b1;
        edges(2);
        chk("R9 float after output enable rise", 1'b1, MARK);
        edges(1);
        chk("R3 output off", 1'b0, 8'h00);

        // R8: output-enable delay alone
        out_en_n = 1'b0;
        edges(2);
        chk("R8 marker during output-enable delay", 1'b1, MARK);
        edges(1);
        chk("R8 data after output-enable delay", 1'b1, 8'h0D);
        chip_sel_n = 1'b1; out_en_n = 1'b1; id_volt = 1'b0;
        edges(4);

        // R8: output enable falls 3 edges after chip select (no penalty)
        addr = 16'h0010; chip_sel_n = 1'b0;
        edges(3);
        chk("R3 output off before enable", 1'b0, 8'h00);
        out_en_n = 1'b0;
        edges(2);
        chk("R8 marker with in-window enable", 1'b1, MARK);
        edges(1);
        chk("R8 data not delayed by in-window enable", 1'b1, 8'h3C);
        chip_sel_n = 1'b1; out_en_n = 1'b1;
        edges(4);

        // R8: output enable falls 4 edges after chip select (one extra cycle)
        chip_sel_n = 1'b0;
        edges(4);
        chk("R3 output off before late enable", 1'b0, 8'h00);
        out_en_n = 1'b0;
        edges(2);
        chk("R8 marker with late enable", 1'b1, MARK);
        edges(1);
        chk("R8 data after late enable", 1'b1, 8'h3C);
        chip_sel_n = 1'b1; out_en_n = 1'b1;
        edges(4);
        chk("R3 standby at end", 1'b0, 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule